// File: doc/BRIEF.md
# Command-Framed Serial Transfer Engine

This block is the device side of a four-wire serial link and runs entirely on the serial clock. Each frame opens when chip select goes low. The host first shifts in a 32-bit command word. From that word the block takes the transfer direction, the address mode, a 2-bit function selector, a 17-bit start address and a byte count. It then runs the data phase. On a write it gathers incoming bytes. On a read it waits out a fixed delay word and then streams bytes back. Every byte becomes one single-cycle access on a plain parallel port that carries a function, an address and a read or write strobe.

The read path is timed so that no asynchronous delay is needed. The first byte is fetched a few clocks before the delay word ends. Its most significant bit is driven out on the last delay edge, and every later byte is fetched while the one before it is still shifting out. A read can also be split across two frames. If chip select rises during the delay word, the decoded command is kept. The next frame then begins with a fresh delay word, followed by the data.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, and until a command has been decoded, sdo, acc_wr, acc_rd and len_clip_err are all 0.
- R2: The command word is shifted in MSB first and is decoded on the 32nd rising edge after chip select falls. The fields are: bit 31 is direction (1 = write, 0 = read), bit 30 is address mode (1 = increment, 0 = fixed), bits 29:28 are the function, bits 27:11 are the start address and bits 10:0 are the byte count. acc_func carries bits 29:28 during that frame's accesses.
- R3: In a write, each byte is taken MSB first. acc_wr is high for exactly the one cycle that follows the rising edge sampling the byte's last bit, with acc_wdata holding that byte.
- R4: Byte k of a transfer (counting from 0) uses the start address plus k, wrapping at 17 bits, in increment mode. In fixed mode it uses the start address.
- R5: A transfer performs exactly as many byte accesses as the byte count. Further clocks in the same frame cause no access. A count of 0 means 2048 bytes.
- R6: For function 1, a byte count above 64 is cut to 64 and len_clip_err becomes 1. That flag stays 1 until reset.
- R7: A read is followed by a 32-clock delay word. The first byte's acc_rd pulse is high in the cycle after the 30th delay edge, and acc_rdata is sampled at the end of that cycle.
- R8: The MSB of the first read byte appears on sdo after the 32nd delay edge. The remaining bits follow MSB first, one per rising edge, with no gap between bytes.
- R9: If chip select rises during the delay word, the read command is kept. The next frame starts a new 32-clock delay word and then returns data from the original address, with no extra fetch.
- R10: If chip select rises during the command word or the data phase, the transfer is dropped. sdo returns to 0, and the next frame is decoded as a new command.
- R11: After the last requested read byte has shifted out, sdo stays 0 and no further acc_rd is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csn | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |
| acc_func | output | 2 | Function selector of the current access |
| acc_addr | output | 17 | Byte address of the current access |
| acc_wr | output | 1 | Single-cycle write strobe |
| acc_wdata | output | 8 | Write byte |
| acc_rd | output | 1 | Single-cycle read strobe |
| acc_rdata | input | 8 | Read byte, valid during the acc_rd cycle |
| len_clip_err | output | 1 | Sticky flag: a function-1 count was cut to 64 |

## Verification
A wrong bit or phase counter shows up at once at the ports. A write strobe lands one edge early or late and carries a shifted byte. A read byte appears rotated on sdo, or its fetch pulse moves away from the 30th delay edge. Faults in the address or remaining-count registers surface at the first access after they occur: as a wrong acc_addr, as a strobe count that differs from the decoded length, or as sdo failing to drop to zero after the final byte. A pending-read flag that is lost or kept too long shows only in the frame after a split read, which either returns shifted data or decodes its first 32 bits as a command.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int CMD_W  = 32;
    localparam int ADDR_W = 17;
    localparam int LEN_W  = 11;
    localparam int FN_W   = 2;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_DELAY,
        PH_WDATA,
        PH_RDATA,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic              wr;
        logic              inc;
        logic [FN_W-1:0]   fn;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W:0]    nbytes;
    } cmd_t;

endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cmd_pkg::*;
#(
    parameter int F1_CAP = 64
) (
    input  logic [CMD_W-1:0] word,
    output cmd_t             cmd,
    output logic             clipped
);

    localparam logic [LEN_W:0] MAX_BYTES = (LEN_W+1)'(1 << LEN_W);
    localparam logic [LEN_W:0] CAP_BYTES = (LEN_W+1)'(F1_CAP);

    logic [LEN_W-1:0] raw_len;
    logic [LEN_W:0]   full_len;

    always_comb begin
        raw_len    = word[LEN_W-1:0];
        full_len   = (raw_len == '0) ? MAX_BYTES : {1'b0, raw_len};
        cmd.wr     = word[CMD_W-1];
        cmd.inc    = word[CMD_W-2];
        cmd.fn     = word[CMD_W-3 -: FN_W];
        cmd.addr   = word[LEN_W +: ADDR_W];
        clipped    = (cmd.fn == FN_W'(1)) && (full_len > CAP_BYTES);
        cmd.nbytes = clipped ? CAP_BYTES : full_len;
    end

endmodule

// File: rtl/spi_cmd_txser.sv
module spi_cmd_txser
    import spi_cmd_pkg::*;
(
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [BYTE_W-1:0] cap_data,
    input  logic              launch,
    input  logic              shift,
    input  logic              clear,
    output logic              sdo
);

    typedef struct packed {
        logic [BYTE_W-1:0] rbuf;
        logic [BYTE_W-2:0] sh;
        logic              out;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (cap) begin
            d.rbuf = cap_data;
        end
        if (clear) begin
            d.out = 1'b0;
            d.sh  = '0;
        end else if (launch) begin
            {d.out, d.sh} = q.rbuf;
        end else if (shift) begin
            {d.out, d.sh} = {q.sh, 1'b0};
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo = q.out;

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DELAY_CLKS = 32,
    parameter int F1_CAP     = 64
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              csn,
    input  logic              sdi,
    output logic              sdo,
    output logic [FN_W-1:0]   acc_func,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_wr,
    output logic [BYTE_W-1:0] acc_wdata,
    output logic              acc_rd,
    input  logic [BYTE_W-1:0] acc_rdata,
    output logic              len_clip_err
);

    localparam int CNT_W = $clog2((DELAY_CLKS > CMD_W) ? DELAY_CLKS : CMD_W);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CLKS - 1);
    localparam logic [CNT_W-1:0] FETCH_AT = CNT_W'(DELAY_CLKS - 3);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_t            phase;
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-2:0]  sh;
        logic              inc;
        logic [FN_W-1:0]   fn;
        logic              pend;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W:0]    rem;
        logic [ADDR_W-1:0] acc_addr;
        logic [BYTE_W-1:0] wdata;
        logic              wr;
        logic              rd;
        logic              err;
    } eng_t;

    eng_t q, d;

    cmd_t              dec_cmd;
    logic              dec_clip;
    logic              tx_launch;
    logic              tx_shift;
    logic              tx_clear;
    logic              slot;
    phase_t            eph;
    logic [ADDR_W-1:0] nxt_addr;

    spi_cmd_decode #(
        .F1_CAP (F1_CAP)
    ) u_dec (
        .word    ({q.sh, sdi}),
        .cmd     (dec_cmd),
        .clipped (dec_clip)
    );

    always_comb begin
        d         = q;
        d.wr      = 1'b0;
        d.rd      = 1'b0;
        tx_launch = 1'b0;
        tx_shift  = 1'b0;
        tx_clear  = 1'b0;
        slot      = 1'b0;
        nxt_addr  = q.inc ? q.addr + 1'b1 : q.addr;

        eph = q.phase;
        if (q.phase == PH_IDLE) begin
            eph = q.pend ? PH_DELAY : PH_CMD;
        end

        if (csn) begin
            d.phase  = PH_IDLE;
            d.cnt    = '0;
            tx_clear = 1'b1;
        end else begin
            d.phase = eph;
            case (eph)
                PH_CMD: begin
                    d.sh  = {q.sh[CMD_W-3:0], sdi};
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CMD_LAST) begin
                        d.cnt  = '0;
                        d.inc  = dec_cmd.inc;
                        d.fn   = dec_cmd.fn;
                        d.addr = dec_cmd.addr;
                        d.rem  = dec_cmd.nbytes;
                        if (dec_clip) begin
                            d.err = 1'b1;
                        end
                        if (dec_cmd.wr) begin
                            d.phase = PH_WDATA;
                        end else begin
                            d.phase = PH_DELAY;
                            d.pend  = 1'b1;
                        end
                    end
                end
                PH_DELAY: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == FETCH_AT) begin
                        d.rd       = 1'b1;
                        d.acc_addr = q.addr;
                    end
                    if (q.cnt == DLY_LAST) begin
                        slot = 1'b1;
                    end
                end
                PH_WDATA: begin
                    d.sh  = {q.sh[CMD_W-3:0], sdi};
                    d.cnt = (q.cnt == BIT_LAST) ? '0 : q.cnt + 1'b1;
                    if (q.cnt == BIT_LAST) begin
                        d.wr       = 1'b1;
                        d.wdata    = {q.sh[BYTE_W-2:0], sdi};
                        d.acc_addr = q.addr;
                        d.addr     = nxt_addr;
                        d.rem      = q.rem - 1'b1;
                        if (q.rem == (LEN_W+1)'(1)) begin
                            d.phase = PH_DONE;
                        end
                    end
                end
                PH_RDATA: begin
                    d.cnt = (q.cnt == BIT_LAST) ? '0 : q.cnt + 1'b1;
                    if (q.cnt == '0) begin
                        slot = 1'b1;
                    end else begin
                        tx_shift = 1'b1;
                    end
                end
                default: begin
                end
            endcase

            if (slot) begin
                if (q.rem == '0) begin
                    d.phase  = PH_DONE;
                    tx_clear = 1'b1;
                end else begin
                    tx_launch = 1'b1;
                    d.phase   = PH_RDATA;
                    d.cnt     = CNT_W'(1);
                    d.pend    = 1'b0;
                    d.rem     = q.rem - 1'b1;
                    d.addr    = nxt_addr;
                    if (q.rem != (LEN_W+1)'(1)) begin
                        d.rd       = 1'b1;
                        d.acc_addr = nxt_addr;
                    end
                end
            end
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_cmd_txser u_tx (
        .sclk     (sclk),
        .rst_n    (rst_n),
        .cap      (q.rd),
        .cap_data (acc_rdata),
        .launch   (tx_launch),
        .shift    (tx_shift),
        .clear    (tx_clear),
        .sdo      (sdo)
    );

    assign acc_func     = q.fn;
    assign acc_addr     = q.acc_addr;
    assign acc_wr       = q.wr;
    assign acc_wdata    = q.wdata;
    assign acc_rd       = q.rd;
    assign len_clip_err = q.err;

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
    input logic sclk,
    input logic rst_n,
    input logic csn,
    input logic sdo,
    input logic acc_wr,
    input logic acc_rd,
    input logic len_clip_err
);

    AST_WR_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!rst_n)
        acc_wr |=> !acc_wr); // R3

    AST_NO_WR_WITH_RD: assert property (@(posedge sclk) disable iff (!rst_n)
        !(acc_wr && acc_rd)); // R3

    AST_RD_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!rst_n)
        acc_rd |=> !acc_rd); // R7

    AST_CLIP_STICKY: assert property (@(posedge sclk) disable iff (!rst_n)
        len_clip_err |=> len_clip_err); // R6

    AST_DESELECT_QUIET: assert property (@(posedge sclk) disable iff (!rst_n)
        $past(csn) |-> (!acc_wr && !acc_rd && !sdo)); // R10

endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .sclk         (sclk),
    .rst_n        (rst_n),
    .csn          (csn),
    .sdo          (sdo),
    .acc_wr       (acc_wr),
    .acc_rd       (acc_rd),
    .len_clip_err (len_clip_err)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;

    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [1:0]  acc_func;
    logic [16:0] acc_addr;
    logic        acc_wr;
    logic [7:0]  acc_wdata;
    logic        acc_rd;
    logic [7:0]  acc_rdata;
    logic        len_clip_err;

    always #10 sclk = ~sclk;

    // register-space model: byte value derived from the address
    assign acc_rdata = acc_addr[7:0] ^ 8'hA5;

    spi_cmd_engine uut (
        .sclk(sclk), .rst_n(rst_n), .csn(csn), .sdi(sdi), .sdo(sdo),
        .acc_func(acc_func), .acc_addr(acc_addr), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rd(acc_rd), .acc_rdata(acc_rdata),
        .len_clip_err(len_clip_err)
    );

    int checks = 0;
    int fails  = 0;
    int nwr    = 0;
    int nrd    = 0;
    logic [16:0] wr_addr [0:4095];
    logic [7:0]  wr_data [0:4095];
    logic [1:0]  wr_fn   [0:4095];
    logic [16:0] rd_addr [0:4095];

    always @(negedge sclk) begin
        if (acc_wr) begin
            if (nwr < 4096) begin
                wr_addr[nwr] = acc_addr;
                wr_data[nwr] = acc_wdata;
                wr_fn[nwr]   = acc_func;
            end
            nwr++;
        end
        if (acc_rd) begin
            if (nrd < 4096) rd_addr[nrd] = acc_addr;
            nrd++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic put_bit(input logic b);
        @(negedge sclk);
        csn = 1'b0;
        sdi = b;
    endtask

    task automatic send_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) put_bit(w[i]);
    endtask

    task automatic end_frame();
        @(negedge sclk);
        csn = 1'b1;
        sdi = 1'b0;
        repeat (2) @(negedge sclk);
    endtask

    task automatic get_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge sclk);
            csn  = 1'b0;
            sdi  = 1'b0;
            b[i] = sdo;
        end
    endtask

    function automatic int exp_len(input logic [31:0] c);
        int n;
        n = (c[10:0] == 11'd0) ? 2048 : int'(c[10:0]);
        if (c[29:28] == 2'd1 && n > 64) n = 64;
        return n;
    endfunction

    function automatic logic [16:0] exp_addr(input logic [31:0] c, input int k);
        return c[30] ? 17'(c[27:11] + 17'(k)) : c[27:11];
    endfunction

    typedef struct packed {
        logic [31:0] cmd;
        logic [15:0] nxfer;
    } vec_t;

    // cmd = {dir, inc, fn[1:0], addr[16:0], len[10:0]}; nxfer = bytes clocked by host
    localparam vec_t VECS [8] = '{
        '{{1'b1, 1'b1, 2'd2, 17'h00100, 11'd4},   16'd4},
        '{{1'b1, 1'b0, 2'd0, 17'h1FFFF, 11'd3},   16'd5},
        '{{1'b1, 1'b1, 2'd1, 17'h00040, 11'd100}, 16'd70},
        '{{1'b0, 1'b1, 2'd2, 17'h00020, 11'd3},   16'd4},
        '{{1'b0, 1'b0, 2'd3, 17'h00077, 11'd2},   16'd3},
        '{{1'b1, 1'b1, 2'd3, 17'h1FFFE, 11'd2},   16'd2},
        '{{1'b0, 1'b1, 2'd1, 17'h000F0, 11'd1},   16'd2},
        '{{1'b1, 1'b1, 2'd2, 17'h00300, 11'd0},   16'd2048}
    };

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic        clip_exp;
        logic [7:0]  b;
        logic [31:0] c;
        int          n;
        int          w0;
        int          r0;

        clip_exp = 1'b0;
        repeat (3) @(negedge sclk);
        // R1: reset state
        chk("R1 sdo", 32'(sdo), 0);
        chk("R1 acc_wr", 32'(acc_wr), 0);
        chk("R1 acc_rd", 32'(acc_rd), 0);
        chk("R1 len_clip_err", 32'(len_clip_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge sclk);

        for (int v = 0; v < 8; v++) begin
            c  = VECS[v].cmd;
            n  = exp_len(c);
            w0 = nwr;
            r0 = nrd;
            if (c[29:28] == 2'd1 && (c[10:0] == 11'd0 || c[10:0] > 11'd64)) clip_exp = 1'b1;
            send_bits(c, 32);
            if (c[31]) begin
                for (int k = 0; k < int'(VECS[v].nxfer); k++) send_bits(32'((v * 37 + k) & 8'hFF), 8);
                end_frame();
                chk("R5 write count", 32'(nwr - w0), 32'(n));
                for (int k = 0; k < n && k < 8; k++) begin
                    chk("R4 write addr", 32'(wr_addr[w0 + k]), 32'(exp_addr(c, k)));
                    chk("R3 write data", 32'(wr_data[w0 + k]), 32'((v * 37 + k) & 8'hFF));
                    chk("R2 func", 32'(wr_fn[w0 + k]), 32'(c[29:28]));
                end
                if (n > 8) begin
                    chk("R4 last write addr", 32'(wr_addr[w0 + n - 1]), 32'(exp_addr(c, n - 1)));
                    chk("R3 last write data", 32'(wr_data[w0 + n - 1]), 32'((v * 37 + n - 1) & 8'hFF));
                end
            end else begin
                repeat (32) put_bit(1'b0);
                for (int k = 0; k < int'(VECS[v].nxfer); k++) begin
                    get_byte(b);
                    if (k < n) chk("R8 read byte", 32'(b), 32'(exp_addr(c, k)[7:0] ^ 8'hA5));
                    else       chk("R11 sdo idle after last byte", 32'(b), 0);
                end
                end_frame();
                chk("R11 read fetch count", 32'(nrd - r0), 32'(n));
                for (int k = 0; k < n; k++) chk("R4 read addr", 32'(rd_addr[r0 + k]), 32'(exp_addr(c, k)));
            end
            chk("R6 clip flag", 32'(len_clip_err), 32'(clip_exp));
        end

        // R10: abort inside the command word, then a fresh command
        send_bits(32'hC0001234, 20);
        end_frame();
        w0 = nwr;
        send_bits({1'b1, 1'b1, 2'd2, 17'h000A0, 11'd1}, 32);
        send_bits(32'h3C, 8);
        end_frame();
        chk("R10 count after cmd abort", 32'(nwr - w0), 1);
        chk("R10 addr after cmd abort", 32'(wr_addr[w0]), 32'h000A0);
        chk("R10 data after cmd abort", 32'(wr_data[w0]), 32'h3C);

        // R3: strobe timing on a two-byte write
        w0 = nwr;
        send_bits({1'b1, 1'b0, 2'd0, 17'h00005, 11'd2}, 32);
        send_bits(32'h81, 8);
        @(negedge sclk);
        sdi = 1'b0;
        chk("R3 strobe after 8th bit", 32'(acc_wr), 1);
        chk("R3 strobe byte", 32'(acc_wdata), 32'h81);
        for (int i = 0; i < 7; i++) begin
            put_bit(1'b0);
            chk("R3 no strobe mid byte", 32'(acc_wr), 0);
        end
        @(negedge sclk);
        chk("R3 second strobe", 32'(acc_wr), 1);
        end_frame();
        chk("R5 two byte count", 32'(nwr - w0), 2);

        // R9 split read with R7 fetch timing
        r0 = nrd;
        send_bits({1'b0, 1'b1, 2'd2, 17'h00200, 11'd2}, 32);
        repeat (10) put_bit(1'b0);
        end_frame();
        repeat (3) @(negedge sclk);
        chk("R9 no fetch during gap", 32'(nrd - r0), 0);
        for (int j = 1; j <= 32; j++) begin
            put_bit(1'b0);
            if (j == 31 || j == 30 || j == 32) chk("R7 fetch pulse timing", 32'(acc_rd), 32'(j == 31));
        end
        get_byte(b);
        chk("R9 first byte after split", 32'(b), 32'(8'h00 ^ 8'hA5));
        get_byte(b);
        chk("R8 second byte after split", 32'(b), 32'(8'h01 ^ 8'hA5));
        get_byte(b);
        chk("R11 zero after split read", 32'(b), 0);
        end_frame();
        chk("R9 fetch count", 32'(nrd - r0), 2);
        chk("R9 first fetch addr", 32'(rd_addr[r0]), 32'h00200);

        // R10: abort during read data, next frame is a new command
        send_bits({1'b0, 1'b1, 2'd2, 17'h00300, 11'd4}, 32);
        repeat (32) put_bit(1'b0);
        get_byte(b);
        chk("R8 byte before abort", 32'(b), 32'(8'h00 ^ 8'hA5));
        end_frame();
        chk("R10 sdo low after abort", 32'(sdo), 0);
        w0 = nwr;
        send_bits({1'b1, 1'b0, 2'd0, 17'h00044, 11'd1}, 32);
        send_bits(32'h99, 8);
        end_frame();
        chk("R10 write after data abort", 32'(nwr - w0), 1);
        chk("R10 addr after data abort", 32'(wr_addr[w0]), 32'h00044);
        chk("R6 flag still set", 32'(len_clip_err), 1);

        summary();
    end

endmodule